// File: doc/BRIEF.md
# Watchpoint Debug Entry Sequencer

This block controls how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) stops for debug after a data access matches a watchpoint. An internal hit reported from the memory stage and an external watchpoint line are merged into one trigger. The block then lets the instruction that sits behind the watchpointed access finish. If that instruction needs several execute cycles, it finishes all of them. The instruction after it is then cancelled in the execute stage. That cancelled instruction's address is kept as the resume point.

Once the cancel has happened, the block stalls fetch and issue. It fills the decode slot and then two execute-stage slots with debug cycles, and only after that raises the debug acknowledge. The acknowledge stays high until a restart request arrives. Watchpoint activity seen while the block is waiting, entering or halted has no effect.

Top module: `dbg_wp_entry`

## Requirements
- R1: A trigger is the OR of `wp_int` and `wp_ext`. Either one alone, seen while running, starts debug entry in exactly the same way.
- R2: The execute-class encoding is 0 = empty slot, 1 = single-cycle data processing, 2 = memory access, 3 = multi-cycle. If the trigger is seen in cycle T and the class in execute is 0, 1 or 2, or is 3 with `ex_last` = 1, then `ex_squash` is high in cycle T+1.
- R3: If the trigger is seen with class 3 and `ex_last` = 0, entry waits. `ex_squash` rises in the cycle after the first cycle in which class 3 is shown with `ex_last` = 1, or in which a class other than 3 is shown.
- R4: `ex_squash` is only driven when the execute class is not 0, and never for two cycles in a row. If the slot is empty in the cancel cycle, the cancel moves to the next cycle in which a valid instruction is present.
- R5: `ret_addr` takes the value of `ex_addr` from the cycle in which `ex_squash` is high. It holds that value until the next cancel.
- R6: `dbg_ack` rises exactly four cycles after the cycle in which `ex_squash` was high. Those four cycles are one decode debug slot and two execute debug slots, followed by the acknowledge.
- R7: `fetch_stall` and `issue_stall` are high from the cancel cycle through every cycle in which `dbg_ack` is high, and low otherwise.
- R8: `dbg_ack` stays high until `restart` is sampled high. It is low in the following cycle, and the stalls drop in that same cycle.
- R9: Triggers that arrive while waiting for a multi-cycle instruction, during the entry sequence, or while halted are ignored. They produce no extra cancel, they do not extend the acknowledge, and they do not change `ret_addr`.
- R10: A synchronous active-high `rst` returns the block to running, with `dbg_ack`, both stalls and `ex_squash` low and `ret_addr` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_int | input | 1 | Watchpoint hit from the memory-stage comparators |
| wp_ext | input | 1 | Watchpoint line from external logic |
| ex_class | input | 2 | Class of the instruction in execute (encoding in R2) |
| ex_last | input | 1 | Current execute cycle is the instruction's last |
| ex_addr | input | ADDR_W | Address of the instruction in execute |
| restart | input | 1 | Request to leave debug state |
| ex_squash | output | 1 | Cancel the execute-stage instruction (no state update) |
| ret_addr | output | ADDR_W | Captured resume address |
| dbg_ack | output | 1 | Debug acknowledge |
| fetch_stall | output | 1 | Hold the fetch stage |
| issue_stall | output | 1 | Hold issue from decode |

## Verification
The hardest case to reach is a trigger that lands on a multi-cycle instruction and is then followed by an empty execute slot. In that case the cancel slides twice, once for the wait and once for the bubble, before the four-cycle count to the acknowledge begins. Directed sequences set up this chain and also a trigger fired while halted. Seeded random traffic then mixes classes, `ex_last`, triggers and restarts, with a reset in the middle of the run. Every cycle is compared against a cycle model written in the bench from the requirements.

// File: rtl/dbg_wp_pkg.sv
package dbg_wp_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_DP    = 2'd1,
        CLS_MEM   = 2'd2,
        CLS_MULTI = 2'd3
    } iclass_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_KILL  = 3'd2,
        ST_DSLOT = 3'd3,
        ST_EDBG1 = 3'd4,
        ST_EDBG2 = 3'd5,
        ST_HALT  = 3'd6
    } entry_st_e;

    typedef struct packed {
        logic squash;
        logic ack;
        logic stall;
    } entry_ctl_t;

    // The instruction in execute still has cycles left to run.
    function automatic logic still_busy(iclass_e cls, logic last);
        return (cls == CLS_MULTI) && !last;
    endfunction

    function automatic logic slot_valid(iclass_e cls);
        return cls != CLS_NONE;
    endfunction

    function automatic logic in_debug(entry_st_e st);
        return st inside {ST_KILL, ST_DSLOT, ST_EDBG1, ST_EDBG2, ST_HALT};
    endfunction

endpackage

// File: rtl/dbg_wp_merge.sv
module dbg_wp_merge (
    input  logic wp_int,
    input  logic wp_ext,
    output logic trig
);
    assign trig = wp_int | wp_ext;
endmodule

// File: rtl/dbg_wp_fsm.sv
module dbg_wp_fsm
    import dbg_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  iclass_e    cls,
    input  logic       last,
    input  logic       restart,
    output entry_ctl_t ctl
);
    entry_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (trig) st_d = still_busy(cls, last) ? ST_WAIT : ST_KILL;
            ST_WAIT:  st_d = still_busy(cls, last) ? ST_WAIT : ST_KILL;
            ST_KILL:  if (slot_valid(cls)) st_d = ST_DSLOT;
            ST_DSLOT: st_d = ST_EDBG1;
            ST_EDBG1: st_d = ST_EDBG2;
            ST_EDBG2: st_d = ST_HALT;
            ST_HALT:  if (restart) st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    always_comb begin
        ctl.squash = (st_q == ST_KILL) && slot_valid(cls);
        ctl.ack    = (st_q == ST_HALT);
        ctl.stall  = in_debug(st_q);
    end
endmodule

// File: rtl/dbg_wp_resume.sv
module dbg_wp_resume #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] ret
);
    always_ff @(posedge clk) begin
        if (rst)       ret <= '0;
        else if (take) ret <= addr;
    end
endmodule

// File: rtl/dbg_wp_entry.sv
module dbg_wp_entry
    import dbg_wp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_int,
    input  logic              wp_ext,
    input  logic [1:0]        ex_class,
    input  logic              ex_last,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic              restart,
    output logic              ex_squash,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              dbg_ack,
    output logic              fetch_stall,
    output logic              issue_stall
);
    logic       trig;
    entry_ctl_t ctl;
    iclass_e    cls;

    assign cls = iclass_e'(ex_class);

    dbg_wp_merge merge_i (
        .wp_int (wp_int),
        .wp_ext (wp_ext),
        .trig   (trig)
    );

    dbg_wp_fsm fsm_i (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .cls     (cls),
        .last    (ex_last),
        .restart (restart),
        .ctl     (ctl)
    );

    dbg_wp_resume #(.ADDR_W(ADDR_W)) resume_i (
        .clk  (clk),
        .rst  (rst),
        .take (ctl.squash),
        .addr (ex_addr),
        .ret  (ret_addr)
    );

    assign ex_squash   = ctl.squash;
    assign dbg_ack     = ctl.ack;
    assign fetch_stall = ctl.stall;
    assign issue_stall = ctl.stall;
endmodule

// File: rtl/dbg_wp_entry_chk.sv
module dbg_wp_entry_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_int,
    input logic              wp_ext,
    input logic [ADDR_W-1:0] ex_addr,
    input logic              restart,
    input logic              ex_squash,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              dbg_ack,
    input logic              fetch_stall,
    input logic              issue_stall
);
    assert_single_squash_R4: assert property (@(posedge clk) disable iff (rst)
        ex_squash |=> !ex_squash);

    assert_resume_addr_R5: assert property (@(posedge clk) disable iff (rst)
        ex_squash |=> ret_addr == $past(ex_addr));

    assert_ack_delay_R6: assert property (@(posedge clk) disable iff (rst)
        ex_squash |-> ##4 dbg_ack);

    assert_stall_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (ex_squash || dbg_ack) |-> (fetch_stall && issue_stall));

    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_ack && !restart) |=> dbg_ack);

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_ack && restart) |=> (!dbg_ack && !fetch_stall && !issue_stall));

    assert_halt_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (dbg_ack && !restart && (wp_int || wp_ext)) |=> (!ex_squash && $stable(ret_addr)));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!dbg_ack && !fetch_stall && !issue_stall && ret_addr == '0));
endmodule

bind dbg_wp_entry dbg_wp_entry_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wp_int      (wp_int),
    .wp_ext      (wp_ext),
    .ex_addr     (ex_addr),
    .restart     (restart),
    .ex_squash   (ex_squash),
    .ret_addr    (ret_addr),
    .dbg_ack     (dbg_ack),
    .fetch_stall (fetch_stall),
    .issue_stall (issue_stall)
);

// File: tb/dbg_wp_entry_tb_top.sv
`timescale 1ns/1ps
module dbg_wp_entry_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_int = 1'b0, wp_ext = 1'b0, ex_last = 1'b0, restart = 1'b0;
    logic [1:0]    ex_class = 2'd0;
    logic [AW-1:0] ex_addr = '0;
    logic          ex_squash, dbg_ack, fetch_stall, issue_stall;
    logic [AW-1:0] ret_addr;

    int checks = 0;
    int errors = 0;

    // Bench model: 0 run, 1 wait, 2 cancel, 3 dslot, 4 e1, 5 e2, 6 halted
    int            m_st = 0;
    logic [AW-1:0] m_ret = '0;

    always #4 clk = ~clk;

    dbg_wp_entry #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wp_int(wp_int), .wp_ext(wp_ext),
        .ex_class(ex_class), .ex_last(ex_last), .ex_addr(ex_addr),
        .restart(restart), .ex_squash(ex_squash), .ret_addr(ret_addr),
        .dbg_ack(dbg_ack), .fetch_stall(fetch_stall), .issue_stall(issue_stall)
    );

    function automatic logic busy_f(logic [1:0] c, logic l);
        return (c == 2'd3) && !l;
    endfunction

    function automatic int next_f(int s, logic hit, logic [1:0] c, logic l, logic rs);
        case (s)
            0: return hit ? (busy_f(c, l) ? 1 : 2) : 0;
            1: return busy_f(c, l) ? 1 : 2;
            2: return (c != 2'd0) ? 3 : 2;
            3: return 4;
            4: return 5;
            5: return 6;
            6: return rs ? 0 : 6;
            default: return 0;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic wi, input logic we, input logic [1:0] c, input logic l,
                        input logic [AW-1:0] a, input logic rs, input string tag);
        logic exp_sq;
        @(negedge clk);
        wp_int = wi; wp_ext = we; ex_class = c; ex_last = l; ex_addr = a; restart = rs;
        #1;
        exp_sq = (m_st == 2) && (c != 2'd0);
        cmp(tag, "ex_squash R2/R4", AW'(ex_squash), AW'(exp_sq));
        cmp(tag, "ret_addr R5",     ret_addr, m_ret);
        cmp(tag, "dbg_ack R6/R8",   AW'(dbg_ack), AW'(m_st == 6));
        cmp(tag, "fetch_stall R7",  AW'(fetch_stall), AW'(m_st >= 2));
        cmp(tag, "issue_stall R7",  AW'(issue_stall), AW'(m_st >= 2));
        if (exp_sq) m_ret = a;
        m_st = next_f(m_st, wi | we, c, l, rs);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0;
        m_ret = '0;
        #1;
        cmp("R10", "dbg_ack",     AW'(dbg_ack), '0);
        cmp("R10", "fetch_stall", AW'(fetch_stall), '0);
        cmp("R10", "issue_stall", AW'(issue_stall), '0);
        cmp("R10", "ex_squash",   AW'(ex_squash), '0);
        cmp("R10", "ret_addr",    ret_addr, '0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R2: internal hit, single-cycle follower, cancel next cycle
        step(1, 0, 2'd1, 1, 32'h0000_0100, 0, "R2");
        step(0, 0, 2'd1, 1, 32'h0000_0104, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 2'd2, 1, 32'h0000_0200, 0, "R9");
        // R9: triggers while halted change nothing
        for (int i = 0; i < 3; i++) step(1, 1, 2'd1, 1, 32'h0000_0300, 0, "R9");
        step(0, 0, 2'd1, 1, 32'h0, 1, "R8");
        step(0, 0, 2'd1, 1, 32'h0, 0, "R8");

        // R1: external line alone, memory-class follower
        step(0, 1, 2'd2, 1, 32'h0000_0400, 0, "R1");
        step(0, 0, 2'd1, 1, 32'h0000_0408, 0, "R1");
        for (int i = 0; i < 5; i++) step(0, 0, 2'd0, 0, 32'h0, 0, "R6");
        step(0, 0, 2'd0, 0, 32'h0, 1, "R8");

        // R3: multi-cycle follower, then R4: empty slot before cancel
        step(1, 0, 2'd3, 0, 32'h0000_0500, 0, "R3");
        step(1, 0, 2'd3, 0, 32'h0000_0500, 0, "R3");
        step(0, 0, 2'd3, 1, 32'h0000_0500, 0, "R3");
        step(0, 0, 2'd0, 0, 32'h0000_0999, 0, "R4");
        step(0, 0, 2'd0, 0, 32'h0000_0998, 0, "R4");
        step(0, 0, 2'd1, 1, 32'h0000_0504, 0, "R4");
        for (int i = 0; i < 6; i++) step(0, 0, 2'd1, 1, 32'h0, 0, "R6");
        step(0, 0, 2'd1, 1, 32'h0, 1, "R8");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i == 2000) do_reset();
            step(($urandom % 12) == 0, ($urandom % 14) == 0,
                 2'($urandom % 4), 1'($urandom % 3 == 0),
                 $urandom, ($urandom % 4) == 0, "RND");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule